// File: doc/BRIEF.md
# Drive Select, Step and Spin-Up Receiver

This block is the receiving logic inside one disk drive that shares a cable with up to three others. A 2-bit strap picks which of four active-low select lines belongs to this drive. While its own line is the only one pulled low, the drive takes part on the cable:
- step, direction and write inputs are acted on;
- the sensor status lines (track zero, index, write protect) and a ready line are driven;
- otherwise every output is held in its inactive state.

All cable inputs are asynchronous, so each one passes through a two-flop synchronizer before any decision is made. A step request counts only when the step line has been low for at least a set number of clock cycles, and the move fires when that pulse ends. The direction line is sampled at the same instant. The result is a one-cycle inward or outward move strobe for the head actuator.

A spin-up timer follows the motor-on line and reports readiness only after the motor has been on for a set time. The write gate and write data are qualified the same way: each falling edge of the write data line gives a one-cycle flux strobe while writing is enabled.

Top module: `drv_select_motor`

## Requirements
- R1: After reset, `selected`, `selError`, `moveIn`, `moveOut`, `writeEnable` and `fluxPulse` are 0, and `trk0N`, `indexN`, `wpN` and `readyN` are 1.
- R2: Strap value k (0 to 3) on `driveAddr` binds the drive to `selN[k]`. `selected` is 1 exactly when `selN[k]` is the only low bit of `selN`. It settles within 4 clock cycles of a change on `selN`.
- R3: When two or more bits of `selN` are low, `selError` is 1 and `selected` is 0.
- R4: While `selected` is 0, the following hold whatever the inputs do: `trk0N`, `indexN`, `wpN` and `readyN` stay 1; `writeEnable` stays 0; no `moveIn`, `moveOut` or `fluxPulse` strobe occurs.
- R5: While `selected` is 1, `trk0N`, `indexN` and `wpN` are the inverse of `trk0Sense`, `indexSense` and `wpSense`.
- R6: The end of a low pulse on `stepN` (its rising edge) gives exactly one move strobe, one cycle long. The start of the pulse (its falling edge) gives none. The pulse must last at least STEP_MIN_CYCLES clock cycles with the drive selected.
- R7: A low pulse on `stepN` shorter than STEP_MIN_CYCLES cycles gives no move strobe.
- R8: The level of `dirN` at the end of the step pulse sets the direction, not its level at the start. Low gives `moveIn`; high gives `moveOut`.
- R9: `readyN` goes low no earlier than SPINUP_CYCLES and no later than SPINUP_CYCLES+4 cycles after `motorOnN` goes low with the drive selected. It returns high within 4 cycles of `motorOnN` going high.
- R10: `writeEnable` is 1 when the drive is selected and `wrGateN` is low. While it is 1, each falling edge of `wrDataN` gives one one-cycle `fluxPulse`.
- R11: If the drive is deselected during a step pulse, that pulse gives no move strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rstN | input | 1 | Asynchronous reset, active low |
| driveAddr | input | 2 | Strap: selects which select bit this drive answers to |
| selN | input | 4 | Active-low select lines from the cable |
| stepN | input | 1 | Active-low step pulse |
| dirN | input | 1 | Direction: low = inward, high = outward |
| motorOnN | input | 1 | Active-low motor-on request |
| wrGateN | input | 1 | Active-low write gate |
| wrDataN | input | 1 | Write data; a falling edge requests a flux change |
| trk0Sense | input | 1 | Track-zero sensor, active high |
| indexSense | input | 1 | Index sensor, active high |
| wpSense | input | 1 | Write-protect sensor, active high |
| selected | output | 1 | Drive is addressed by exactly its own select line |
| selError | output | 1 | More than one select line is low |
| moveIn | output | 1 | One-cycle strobe: step toward the disk centre |
| moveOut | output | 1 | One-cycle strobe: step away from the disk centre |
| writeEnable | output | 1 | Write current enable |
| fluxPulse | output | 1 | One-cycle flux-change strobe |
| trk0N | output | 1 | Active-low track-zero status |
| indexN | output | 1 | Active-low index status |
| wpN | output | 1 | Active-low write-protect status |
| readyN | output | 1 | Active-low spin-up complete status |

## Verification
The hardest cases to reach are those where timing inside one step pulse decides the outcome:
- a pulse exactly STEP_MIN_CYCLES long against one a single cycle shorter;
- a direction level that changes in the very cycle the step line rises;
- a deselect that arrives while the step line is still low.

The stimulus drives all cable inputs on the falling clock edge. Because every input has the same synchronizer latency, the bench can place the step rise and the direction change in the same cycle and get the low-pulse length exact to one cycle. A negedge monitor counts move strobes before and after the rise, so a strobe on the wrong edge of the pulse is caught.

// File: rtl/drv_select_pkg.sv
`timescale 1ns/1ps
package drv_select_pkg;
  localparam int DRIVES = 4;
  localparam int ADDR_W = $clog2(DRIVES);

  // control -> datapath strobes
  typedef struct packed {
    logic stepCntClr;
    logic spinClr;
  } dpStrobe_t;

  // datapath -> control observations
  typedef struct packed {
    logic [DRIVES-1:0] selLow;
    logic stepLow;
    logic stepRose;
    logic dirLow;
    logic motorOn;
    logic wrGate;
    logic wrDataFell;
    logic stepLongEnough;
    logic spunUp;
  } dpStat_t;
endpackage

// File: rtl/drv_sync2.sv
`timescale 1ns/1ps
module drv_sync2 #(
  parameter int W = 1
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);
  // idle level of every cable line is high
  logic [W-1:0] stage1;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stage1 <= '1;
      dout   <= '1;
    end else begin
      stage1 <= din;
      dout   <= stage1;
    end
  end
endmodule

// File: rtl/drv_datapath.sv
`timescale 1ns/1ps
module drv_datapath
  import drv_select_pkg::*;
#(
  parameter int STEP_MIN_CYCLES = 40,
  parameter int SPINUP_CYCLES   = 50_000_000
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [DRIVES-1:0] selN,
  input  logic              stepN,
  input  logic              dirN,
  input  logic              motorOnN,
  input  logic              wrGateN,
  input  logic              wrDataN,
  input  dpStrobe_t         strobe,
  output dpStat_t           stat
);
  localparam int SYNC_W = DRIVES + 5;
  localparam int STEP_W = $clog2(STEP_MIN_CYCLES + 1);
  localparam int SPIN_W = $clog2(SPINUP_CYCLES + 1);
  localparam logic [STEP_W-1:0] STEP_LIM = STEP_W'(STEP_MIN_CYCLES);
  localparam logic [SPIN_W-1:0] SPIN_LIM = SPIN_W'(SPINUP_CYCLES);

  logic [SYNC_W-1:0] rawVec, syncVec;
  logic [DRIVES-1:0] selSync;
  logic stepSync, dirSync, motorSync, wrGateSync, wrDataSync;
  logic stepPrev, wrDataPrev;
  logic [STEP_W-1:0] stepCnt;
  logic [SPIN_W-1:0] spinCnt;

  assign rawVec = {selN, stepN, dirN, motorOnN, wrGateN, wrDataN};

  drv_sync2 #(.W(SYNC_W)) u_sync (
    .clk  (clk),
    .rstN (rstN),
    .din  (rawVec),
    .dout (syncVec)
  );

  assign {selSync, stepSync, dirSync, motorSync, wrGateSync, wrDataSync} = syncVec;

  // edge history
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stepPrev   <= 1'b1;
      wrDataPrev <= 1'b1;
    end else begin
      stepPrev   <= stepSync;
      wrDataPrev <= wrDataSync;
    end
  end

  // cycles spent low on the step line, saturating at the threshold
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                  stepCnt <= '0;
    else if (strobe.stepCntClr) stepCnt <= '0;
    else if (stepCnt < STEP_LIM) stepCnt <= stepCnt + 1'b1;
  end

  // spin-up delay, saturating at the limit
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                   spinCnt <= '0;
    else if (strobe.spinClr)     spinCnt <= '0;
    else if (spinCnt < SPIN_LIM) spinCnt <= spinCnt + 1'b1;
  end

  always_comb begin
    stat.selLow         = ~selSync;
    stat.stepLow        = ~stepSync;
    stat.stepRose       = stepSync & ~stepPrev;
    stat.dirLow         = ~dirSync;
    stat.motorOn        = ~motorSync;
    stat.wrGate         = ~wrGateSync;
    stat.wrDataFell     = wrDataPrev & ~wrDataSync;
    stat.stepLongEnough = (stepCnt >= STEP_LIM);
    stat.spunUp         = (spinCnt == SPIN_LIM);
  end
endmodule

// File: rtl/drv_control.sv
`timescale 1ns/1ps
module drv_control
  import drv_select_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] driveAddr,
  input  dpStat_t           stat,
  input  logic              trk0Sense,
  input  logic              indexSense,
  input  logic              wpSense,
  output dpStrobe_t         strobe,
  output logic              selected,
  output logic              selError,
  output logic              moveIn,
  output logic              moveOut,
  output logic              writeEnable,
  output logic              fluxPulse,
  output logic              trk0N,
  output logic              indexN,
  output logic              wpN,
  output logic              readyN
);
  localparam int CNT_W = $clog2(DRIVES + 1);

  logic [CNT_W-1:0] lowCount;
  logic selHit, stepOk;

  assign lowCount = CNT_W'($countones(stat.selLow));
  assign selHit   = stat.selLow[driveAddr];
  assign stepOk   = selected & stat.stepRose & stat.stepLongEnough;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      selected  <= 1'b0;
      selError  <= 1'b0;
      moveIn    <= 1'b0;
      moveOut   <= 1'b0;
      fluxPulse <= 1'b0;
    end else begin
      selected  <= (lowCount == CNT_W'(1)) & selHit;
      selError  <= (lowCount > CNT_W'(1));
      moveIn    <= stepOk & stat.dirLow;
      moveOut   <= stepOk & ~stat.dirLow;
      fluxPulse <= selected & stat.wrGate & stat.wrDataFell;
    end
  end

  always_comb begin
    strobe.stepCntClr = ~stat.stepLow | ~selected;
    strobe.spinClr    = ~stat.motorOn;
    writeEnable       = selected & stat.wrGate;
    trk0N             = ~(selected & trk0Sense);
    indexN            = ~(selected & indexSense);
    wpN               = ~(selected & wpSense);
    readyN            = ~(selected & stat.spunUp);
  end
endmodule

// File: rtl/drv_select_motor.sv
`timescale 1ns/1ps
module drv_select_motor
  import drv_select_pkg::*;
#(
  parameter int STEP_MIN_CYCLES = 40,
  parameter int SPINUP_CYCLES   = 50_000_000
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] driveAddr,
  input  logic [DRIVES-1:0] selN,
  input  logic              stepN,
  input  logic              dirN,
  input  logic              motorOnN,
  input  logic              wrGateN,
  input  logic              wrDataN,
  input  logic              trk0Sense,
  input  logic              indexSense,
  input  logic              wpSense,
  output logic              selected,
  output logic              selError,
  output logic              moveIn,
  output logic              moveOut,
  output logic              writeEnable,
  output logic              fluxPulse,
  output logic              trk0N,
  output logic              indexN,
  output logic              wpN,
  output logic              readyN
);
  dpStrobe_t strobe;
  dpStat_t   stat;

  drv_datapath #(
    .STEP_MIN_CYCLES (STEP_MIN_CYCLES),
    .SPINUP_CYCLES   (SPINUP_CYCLES)
  ) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .selN     (selN),
    .stepN    (stepN),
    .dirN     (dirN),
    .motorOnN (motorOnN),
    .wrGateN  (wrGateN),
    .wrDataN  (wrDataN),
    .strobe   (strobe),
    .stat     (stat)
  );

  drv_control u_ctl (
    .clk         (clk),
    .rstN        (rstN),
    .driveAddr   (driveAddr),
    .stat        (stat),
    .trk0Sense   (trk0Sense),
    .indexSense  (indexSense),
    .wpSense     (wpSense),
    .strobe      (strobe),
    .selected    (selected),
    .selError    (selError),
    .moveIn      (moveIn),
    .moveOut     (moveOut),
    .writeEnable (writeEnable),
    .fluxPulse   (fluxPulse),
    .trk0N       (trk0N),
    .indexN      (indexN),
    .wpN         (wpN),
    .readyN      (readyN)
  );
endmodule

// File: rtl/drv_select_motor_chk.sv
`timescale 1ns/1ps
module drv_select_motor_chk (
  input logic clk,
  input logic rstN,
  input logic selected,
  input logic selError,
  input logic moveIn,
  input logic moveOut,
  input logic writeEnable,
  input logic fluxPulse,
  input logic trk0N,
  input logic indexN,
  input logic wpN,
  input logic readyN
);
  // R8: one direction per move
  p_one_dir_r8: assert property (@(posedge clk) disable iff (!rstN)
    !(moveIn && moveOut));

  // R6: move strobes last one cycle
  p_in_single_r6: assert property (@(posedge clk) disable iff (!rstN)
    moveIn |=> !moveIn);
  p_out_single_r6: assert property (@(posedge clk) disable iff (!rstN)
    moveOut |=> !moveOut);

  // R4: a move needs the drive to have been selected
  p_move_sel_r4: assert property (@(posedge clk) disable iff (!rstN)
    (moveIn || moveOut) |-> $past(selected));

  // R4: status held inactive while deselected
  p_desel_quiet_r4: assert property (@(posedge clk) disable iff (!rstN)
    !selected |-> (trk0N && indexN && wpN && readyN && !writeEnable));

  // R3: a select conflict never coexists with selection
  p_conflict_r3: assert property (@(posedge clk) disable iff (!rstN)
    selError |-> !selected);

  // R10: flux strobe only while writing was enabled
  p_flux_we_r10: assert property (@(posedge clk) disable iff (!rstN)
    fluxPulse |-> $past(writeEnable));
  p_flux_single_r10: assert property (@(posedge clk) disable iff (!rstN)
    fluxPulse |=> !fluxPulse);
endmodule

bind drv_select_motor drv_select_motor_chk u_chk (.*);

// File: tb/drv_select_motor_tb.sv
`timescale 1ns/1ps
module drv_select_motor_tb;
  localparam int STEP_MIN = 8;
  localparam int SPIN     = 100;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [1:0] driveAddr = 2'd1;
  logic [3:0] selN = 4'hF;
  logic stepN = 1'b1, dirN = 1'b1, motorOnN = 1'b1, wrGateN = 1'b1, wrDataN = 1'b1;
  logic trk0Sense = 1'b0, indexSense = 1'b0, wpSense = 1'b0;
  logic selected, selError, moveIn, moveOut, writeEnable, fluxPulse;
  logic trk0N, indexN, wpN, readyN;

  int checks = 0;
  int errors = 0;
  int inCnt = 0, outCnt = 0, fluxCnt = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  drv_select_motor #(.STEP_MIN_CYCLES(STEP_MIN), .SPINUP_CYCLES(SPIN)) u_dut (
    .clk(clk), .rstN(rstN), .driveAddr(driveAddr), .selN(selN), .stepN(stepN),
    .dirN(dirN), .motorOnN(motorOnN), .wrGateN(wrGateN), .wrDataN(wrDataN),
    .trk0Sense(trk0Sense), .indexSense(indexSense), .wpSense(wpSense),
    .selected(selected), .selError(selError), .moveIn(moveIn), .moveOut(moveOut),
    .writeEnable(writeEnable), .fluxPulse(fluxPulse), .trk0N(trk0N),
    .indexN(indexN), .wpN(wpN), .readyN(readyN)
  );

  always @(negedge clk) begin
    if (moveIn)    inCnt++;
    if (moveOut)   outCnt++;
    if (fluxPulse) fluxCnt++;
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic waitCyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  // low pulse of lowCyc cycles; dirTrail applied in the cycle the pulse ends
  task automatic doStep(input int lowCyc, input logic dirLead, input logic dirTrail,
                        output int preRise);
    inCnt = 0; outCnt = 0;
    dirN = dirLead;
    waitCyc(4);
    stepN = 1'b0;
    waitCyc(lowCyc);
    preRise = inCnt + outCnt;
    dirN  = dirTrail;
    stepN = 1'b1;
    waitCyc(8);
  endtask

  // {selN, addr, expSelected, expError}
  localparam logic [7:0] VEC [9] = '{
    8'b1110_00_1_0, 8'b1101_00_0_0, 8'b1101_01_1_0, 8'b1011_10_1_0,
    8'b0111_11_1_0, 8'b0111_10_0_0, 8'b1111_01_0_0, 8'b1100_01_0_1,
    8'b0000_11_0_1
  };

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin : main
    int pre;
    int t;
    waitCyc(3);
    rstN = 1'b1;
    waitCyc(2);
    // R1 reset state
    chk(!selected && !selError && !moveIn && !moveOut && !writeEnable && !fluxPulse
        && trk0N && indexN && wpN && readyN, "R1 reset state",
        {selected, selError, writeEnable, readyN}, 4'b0001);

    // R2 / R3 address table
    for (int i = 0; i < 9; i++) begin
      selN = VEC[i][7:4];
      driveAddr = VEC[i][3:2];
      waitCyc(5);
      chk(selected == VEC[i][1], $sformatf("R2 select vector %0d", i), selected, VEC[i][1]);
      chk(selError == VEC[i][0], $sformatf("R3 conflict vector %0d", i), selError, VEC[i][0]);
    end

    // R4 deselected: everything active, outputs quiet
    selN = 4'b1111; driveAddr = 2'd1;
    trk0Sense = 1'b1; indexSense = 1'b1; wpSense = 1'b1; wrGateN = 1'b0;
    waitCyc(5);
    chk(trk0N && indexN && wpN && !writeEnable, "R4 status held while deselected",
        {trk0N, indexN, wpN, writeEnable}, 4'b1110);
    doStep(12, 1'b0, 1'b0, pre);
    chk(inCnt + outCnt == 0, "R4 step ignored while deselected", inCnt + outCnt, 0);
    fluxCnt = 0;
    repeat (2) begin wrDataN = 1'b0; waitCyc(3); wrDataN = 1'b1; waitCyc(3); end
    chk(fluxCnt == 0, "R4 write data ignored while deselected", fluxCnt, 0);
    wrGateN = 1'b1;

    // R5 status pass-through when selected
    selN = 4'b1101;
    waitCyc(5);
    chk({trk0N, indexN, wpN} == 3'b000, "R5 status follows sensors", {trk0N, indexN, wpN}, 0);
    trk0Sense = 1'b0; wpSense = 1'b0;
    waitCyc(1);
    chk({trk0N, indexN, wpN} == 3'b101, "R5 status follows sensors mixed",
        {trk0N, indexN, wpN}, 3'b101);

    // R6 / R8 steps
    doStep(12, 1'b0, 1'b0, pre);
    chk(pre == 0, "R6 no move on leading edge", pre, 0);
    chk(inCnt == 1 && outCnt == 0, "R8 dir low gives inward move", inCnt * 10 + outCnt, 10);
    doStep(12, 1'b1, 1'b1, pre);
    chk(inCnt == 0 && outCnt == 1, "R8 dir high gives outward move", inCnt * 10 + outCnt, 1);
    doStep(STEP_MIN, 1'b1, 1'b1, pre);
    chk(outCnt == 1 && inCnt == 0, "R6 pulse of exactly minimum length accepted", outCnt, 1);
    doStep(STEP_MIN - 1, 1'b0, 1'b0, pre);
    chk(inCnt + outCnt == 0, "R7 short pulse rejected", inCnt + outCnt, 0);
    doStep(2, 1'b0, 1'b0, pre);
    chk(inCnt + outCnt == 0, "R7 very short pulse rejected", inCnt + outCnt, 0);
    doStep(12, 1'b1, 1'b0, pre);
    chk(inCnt == 1 && outCnt == 0, "R8 direction taken at trailing edge", inCnt * 10 + outCnt, 10);
    doStep(12, 1'b0, 1'b1, pre);
    chk(inCnt == 0 && outCnt == 1, "R8 direction taken at trailing edge (out)",
        inCnt * 10 + outCnt, 1);

    // R11 deselect during pulse
    inCnt = 0; outCnt = 0;
    dirN = 1'b0; waitCyc(4);
    stepN = 1'b0; waitCyc(10);
    selN = 4'b1111; waitCyc(6);
    stepN = 1'b1; waitCyc(3);
    selN = 4'b1101; waitCyc(8);
    chk(inCnt + outCnt == 0, "R11 deselect mid pulse cancels move", inCnt + outCnt, 0);

    // R9 spin-up
    motorOnN = 1'b0;
    t = 0;
    while (readyN && t < SPIN + 20) begin waitCyc(1); t++; end
    chk(t >= SPIN && t <= SPIN + 4, "R9 ready after spin-up delay", t, SPIN + 2);
    motorOnN = 1'b1;
    t = 0;
    while (!readyN && t < 20) begin waitCyc(1); t++; end
    chk(t <= 4, "R9 ready drops promptly", t, 3);

    // R10 write path
    wrGateN = 1'b0;
    waitCyc(4);
    chk(writeEnable == 1'b1, "R10 write enable when gated and selected", writeEnable, 1);
    fluxCnt = 0;
    repeat (3) begin wrDataN = 1'b0; waitCyc(3); wrDataN = 1'b1; waitCyc(3); end
    waitCyc(4);
    chk(fluxCnt == 3, "R10 one flux strobe per falling edge", fluxCnt, 3);
    wrGateN = 1'b1;
    waitCyc(4);
    fluxCnt = 0;
    repeat (2) begin wrDataN = 1'b0; waitCyc(3); wrDataN = 1'b1; waitCyc(3); end
    chk(fluxCnt == 0 && !writeEnable, "R10 no flux without write gate", fluxCnt, 0);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule